// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block sits beside a floating-point datapath and holds a sticky status register of exception flags. Each completed operation presents its raw exception flags, an ignore mask, a software-completion mode bit, a trap-enable mask and the number of its destination register, all on a valid strobe. The block accumulates the flags into the sticky status and decides whether the operation raises an arithmetic trap.

When it traps, the block produces a summary word and a one-hot mask of the destination register. Both are registered and appear, together with a one-cycle trap pulse, in the cycle after the strobe. Without software completion, every flag that the ignore mask leaves traps. With software completion, ignored flags never reach the sticky status, and the summary reports only the flags that are enabled, plus a marker bit. The status can be overwritten through a simple write port and is always visible on an output.

Top module: `fp_exc_trap`

## Requirements
- R1: A synchronous reset clears the status, the trap pulse, the summary and the register mask to zero.
- R2: Flag bit positions are bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact and bit 5 integer overflow. This applies to flags, ignore mask, enable mask, write data and status. In the summary, bit 0 is the software-completion marker and bits 6:1 carry the flags in the same order.
- R3: Without software completion (op_swc=0), a strobe ORs all raw flags into the status, including the ignored ones.
- R4: Without software completion, a strobe traps exactly when the flags left after the ignore mask are nonzero. The summary then holds those flags with the marker at 0, and trap_en has no effect.
- R5: With software completion (op_swc=1), a strobe ORs only the unignored flags into the status.
- R6: With software completion, a strobe traps exactly when the unignored flags are nonzero, even if trap_en removes all of them. The summary then holds the unignored flags ANDed with trap_en, with the marker at 1.
- R7: On a trap, the register mask equals 1 shifted left by op_dest. When there is no trap, the mask and the summary are zero.
- R8: Trap, summary and mask appear in the cycle after the strobe and last one cycle. A cycle without a strobe changes no status bit, raises no trap and returns the summary and the mask to zero.
- R9: A write sets the status to csr_wdata. A flag update in the same cycle is ORed on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Strobe marking an operation result |
| op_flags | input | 6 | Raw exception flags of the operation |
| op_ignore | input | 6 | Flags the operation ignores |
| op_dest | input | REG_W (5) | Destination register number |
| op_swc | input | 1 | Software-completion mode |
| trap_en | input | 6 | Trap enable mask, used with software completion |
| csr_we | input | 1 | Status write enable |
| csr_wdata | input | 6 | Status write data |
| status | output | 6 | Sticky exception status |
| trap | output | 1 | One-cycle trap pulse |
| trap_summary | output | 7 | Marker bit and reported flags of the trap |
| trap_regmask | output | 2**REG_W (32) | One-hot destination register of the trap |

## Verification
The sticky status appears directly on a port, so a bit that is lost, set wrongly or set by an ignored flag shows in the cycle after the strobe that caused it. It stays visible until a write or a reset clears it. A wrong mode decision shows at once as a missing or extra trap pulse, or as a wrong marker or flag field in the summary. Write/update collisions, software-completion traps whose flags are all disabled, and the lowest and highest register numbers are driven on purpose, because a fault there hides under random stimulus.

// File: rtl/fp_exc_trap.sv
module fp_exc_trap #(
  parameter int REG_W = 5,
  parameter int NFLAG = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   op_valid,
  input  logic [NFLAG-1:0]       op_flags,
  input  logic [NFLAG-1:0]       op_ignore,
  input  logic [REG_W-1:0]       op_dest,
  input  logic                   op_swc,
  input  logic [NFLAG-1:0]       trap_en,
  input  logic                   csr_we,
  input  logic [NFLAG-1:0]       csr_wdata,
  output logic [NFLAG-1:0]       status,
  output logic                   trap,
  output logic [NFLAG:0]         trap_summary,
  output logic [(1<<REG_W)-1:0]  trap_regmask
);
  localparam int NREG = 1 << REG_W;

  logic [NFLAG-1:0] kept;
  logic [NFLAG-1:0] sticky_set;
  logic [NFLAG-1:0] report;
  logic             fire;

  assign kept       = op_flags & ~op_ignore;
  assign sticky_set = !op_valid ? '0 : (op_swc ? kept : op_flags);
  assign fire       = op_valid && (kept != '0);
  assign report     = op_swc ? (kept & trap_en) : kept;

  always_ff @(posedge clk) begin
    if (rst) begin
      status       <= '0;
      trap         <= 1'b0;
      trap_summary <= '0;
      trap_regmask <= '0;
    end else begin
      status       <= (csr_we ? csr_wdata : status) | sticky_set;
      trap         <= fire;
      trap_summary <= fire ? {report, op_swc} : '0;
      trap_regmask <= fire ? (NREG'(1) << op_dest) : '0;
    end
  end
endmodule

module fp_exc_trap_chk #(
  parameter int REG_W = 5,
  parameter int NFLAG = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   op_valid,
  input logic [NFLAG-1:0]       op_flags,
  input logic [NFLAG-1:0]       op_ignore,
  input logic                   op_swc,
  input logic                   csr_we,
  input logic [NFLAG-1:0]       status,
  input logic                   trap,
  input logic [NFLAG:0]         trap_summary,
  input logic [(1<<REG_W)-1:0]  trap_regmask
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status == '0 && !trap && trap_summary == '0 && trap_regmask == '0));

  // R3
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_we |=> ((status & $past(status)) == $past(status)));

  // R5
  swc_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!csr_we && op_valid && op_swc) |=>
      ((status & ~$past(status) & $past(op_ignore)) == '0));

  // R8
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!trap && trap_summary == '0));

  // R7
  regmask_chk: assert property (@(posedge clk) disable iff (rst)
    trap == ($countones(trap_regmask) == 1) && $onehot0(trap_regmask));

  // R6
  marker_chk: assert property (@(posedge clk) disable iff (rst)
    trap_summary[0] |-> trap);
endmodule

bind fp_exc_trap fp_exc_trap_chk #(.REG_W(REG_W), .NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
  .op_ignore(op_ignore), .op_swc(op_swc), .csr_we(csr_we), .status(status),
  .trap(trap), .trap_summary(trap_summary), .trap_regmask(trap_regmask)
);

// File: tb/test_fp_exc_trap.sv
`timescale 1ns/1ps
module test_fp_exc_trap;
  localparam int REG_W = 5;
  localparam int NFLAG = 6;
  localparam int NREG  = 1 << REG_W;

  logic clk = 1'b0;
  logic rst;
  logic op_valid, op_swc, csr_we;
  logic [NFLAG-1:0] op_flags, op_ignore, trap_en, csr_wdata;
  logic [REG_W-1:0] op_dest;
  logic [NFLAG-1:0] status;
  logic trap;
  logic [NFLAG:0] trap_summary;
  logic [NREG-1:0] trap_regmask;

  int checks = 0;
  int errors = 0;
  logic [NFLAG-1:0] m_status;

  always #2 clk = ~clk;

  fp_exc_trap #(.REG_W(REG_W), .NFLAG(NFLAG)) i_fp_exc_trap (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
    .op_ignore(op_ignore), .op_dest(op_dest), .op_swc(op_swc),
    .trap_en(trap_en), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .status(status), .trap(trap), .trap_summary(trap_summary),
    .trap_regmask(trap_regmask)
  );

  function automatic logic [NFLAG:0] exp_summary(logic v, logic [NFLAG-1:0] f,
      logic [NFLAG-1:0] ig, logic swc, logic [NFLAG-1:0] en);
    logic [NFLAG-1:0] k = f & ~ig;
    if (!v || k == '0) return '0;
    return swc ? {k & en, 1'b1} : {k, 1'b0};
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(logic v, logic [NFLAG-1:0] f, logic [NFLAG-1:0] ig,
      logic [REG_W-1:0] d, logic swc, logic [NFLAG-1:0] en, logic we,
      logic [NFLAG-1:0] wd, string tag);
    logic [NFLAG:0] es;
    logic [NFLAG-1:0] setm;
    setm = !v ? '0 : (swc ? (f & ~ig) : f);
    m_status = (we ? wd : m_status) | setm;
    es = exp_summary(v, f, ig, swc, en);
    op_valid = v; op_flags = f; op_ignore = ig; op_dest = d;
    op_swc = swc; trap_en = en; csr_we = we; csr_wdata = wd;
    @(negedge clk);
    op_valid = 1'b0; csr_we = 1'b0;
    check(tag, "status", 64'(status), 64'(m_status));
    check(tag, "trap", 64'(trap), 64'(es != '0 || (v && (f & ~ig) != '0)));
    check(tag, "summary", 64'(trap_summary), 64'(es));
    check(tag, "regmask", 64'(trap_regmask),
          (v && (f & ~ig) != '0) ? (64'(1) << d) : 64'(0));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; op_valid = 0; op_flags = 0; op_ignore = 0; op_dest = 0;
    op_swc = 0; trap_en = 0; csr_we = 0; csr_wdata = 0;
    m_status = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "status", 64'(status), 0);
    check("R1", "trap", 64'(trap), 0);
    check("R1", "summary", 64'(trap_summary), 0);
    check("R1", "regmask", 64'(trap_regmask), 0);
    rst = 1'b0;
    // R3 R4: ignored inexact still sticky, no trap
    do_op(1, 6'b010000, 6'b010000, 5'd3, 0, 6'h00, 0, 0, "R3");
    // R4 R2: invalid traps, trap_en has no effect; register 0
    do_op(1, 6'b000001, 6'b000000, 5'd0, 0, 6'h00, 0, 0, "R4");
    // R8: no strobe, flags present
    do_op(0, 6'b111111, 6'b000000, 5'd9, 0, 6'h3f, 0, 0, "R8");
    // R9: write clears, concurrent overflow ORed
    do_op(1, 6'b000100, 6'b000000, 5'd31, 0, 6'h00, 1, 6'b100000, "R9");
    // R9: plain write
    do_op(0, 6'b000000, 6'b000000, 5'd0, 0, 6'h00, 1, 6'b000000, "R9");
    // R5: ignored underflow not sticky in swc mode
    do_op(1, 6'b001000, 6'b001000, 5'd7, 1, 6'h3f, 0, 0, "R5");
    // R6: trap with all flags disabled, only marker
    do_op(1, 6'b000010, 6'b000000, 5'd12, 1, 6'h00, 0, 0, "R6");
    // R6 R2: partial enable of divide-by-zero and integer overflow
    do_op(1, 6'b100010, 6'b000000, 5'd31, 1, 6'b100000, 0, 0, "R6");
    // R7: highest register, consecutive strobes
    do_op(1, 6'b000100, 6'b000000, 5'd31, 0, 6'h00, 0, 0, "R7");
    do_op(1, 6'b000100, 6'b000000, 5'd1, 0, 6'h00, 0, 0, "R7");
    // R8: pulse ends without strobe
    do_op(0, 6'b000000, 6'b000000, 5'd0, 0, 6'h00, 0, 0, "R8");
    for (int i = 0; i < 400; i++) begin
      logic swc;
      swc = 1'($urandom);
      do_op(($urandom % 4) != 0, 6'($urandom), 6'($urandom), 5'($urandom),
            swc, 6'($urandom), ($urandom % 8) == 0, 6'($urandom),
            swc ? "R5 R6 R7 random" : "R3 R4 R7 random");
    end
    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_status = '0;
    check("R1", "status", 64'(status), 0);
    check("R1", "trap", 64'(trap), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule